// File: doc/BRIEF.md
# Multi-Channel Packet Rate Limiter

This block enforces a packet-rate ceiling for four filter channels over repeating time windows. A single shared prescaler counts main-clock cycles and starts a new window every `prescale` cycles. Each channel counts the packets its upstream filter flags during the current window. It judges every flagged packet against that channel's 8-bit allowance, and all window counts return to zero when a new window begins.

Packets enter as single-cycle per-channel hit pulses. The block accepts a hit on every cycle on every channel, so there is no back-pressure and no ready signal. Every hit produces exactly one verdict on the following cycle: `verdict_vld` pulses for that channel, and `over_limit` tells the downstream drop logic whether the packet exceeded the allowance. Filter matching and the drop action itself belong to neighbouring blocks.

Top module: `pkt_rate_limiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `verdict_vld` and `over_limit` are all zero. The window counter and every channel count start from zero.
- R2: With a nonzero prescale value P, a new window starts every P cycles. The first window begins at reset release. When a window starts, every channel count is zero for the packets judged in that cycle.
- R3: A hit on channel i in cycle n drives `verdict_vld[i]` high in cycle n+1 only. `over_limit[i]` is meaningful only when `verdict_vld[i]` is 1 and is 0 otherwise.
- R4: A hit is reported over-limit (`over_limit[i]`=1) when the number of hits that channel has already taken in the window is at least its allowance. The first `allowance` hits in a window pass with `over_limit[i]`=0.
- R5: An allowance of zero reports every hit on that channel as over-limit while windows are running.
- R6: A prescale value of zero stops window generation. All verdicts then pass, and the window counter and channel counts are held at zero, so the first window after a nonzero value is written is a fresh one.
- R7: A channel count saturates at 255 and does not wrap inside a window. With an allowance of 255, hits after the 255th in a window are over-limit.
- R8: Channels are independent. The hits and allowance of one channel never change the verdicts of another.
- R9: A hit in the cycle in which a window starts is counted in the new window.
- R10: If the prescale value is lowered to or below the current position in the window, the next window starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prescale | input | 20 | Window length in clock cycles; 0 disables windows |
| allowance | input | 32 | Per-channel allowance, channel i in bits [8i+7:8i] |
| hit | input | 4 | Per-channel single-cycle packet-match pulse |
| verdict_vld | output | 4 | Per-channel verdict strobe, one cycle after a hit |
| over_limit | output | 4 | Per-channel verdict: 1 means the packet exceeded the allowance |

## Verification
The hardest condition to reach from the ports is a saturated count: a channel has to take more than 255 hits inside one window without a window restart. The stimulus first writes prescale zero, which resets the window position. It then selects a 1000-cycle window and drives 300 back-to-back hits on one channel that has an allowance of 255. The window-start cycle is another case that needs care. Continuous hits across several short windows, and a prescale value lowered in the middle of a window, make packets land exactly on the restart cycle.

// File: rtl/rl_pkg.sv
package rl_pkg;
  localparam int NUM_CH     = 4;
  localparam int PRESCALE_W = 20;
  localparam int ALLOW_W    = 8;
endpackage

// File: rtl/rl_window_gen.sv
module rl_window_gen #(
  parameter int PRESCALE_W = rl_pkg::PRESCALE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PRESCALE_W-1:0] prescale_i,
  output logic                  active_o,
  output logic                  tick_o
);
  localparam logic [PRESCALE_W-1:0] ONE = PRESCALE_W'(1);

  logic [PRESCALE_W-1:0] pos_q;

  assign active_o = (prescale_i != '0);
  // >= covers a prescale value lowered below the current position
  assign tick_o   = active_o && (pos_q >= (prescale_i - ONE));

  always_ff @(posedge clk) begin
    if (!rst_n)          pos_q <= '0;
    else if (!active_o)  pos_q <= '0;
    else if (tick_o)     pos_q <= '0;
    else                 pos_q <= pos_q + ONE;
  end

  // R2
  window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (pos_q == '0));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale_i == '0) |=> (pos_q == '0));
endmodule

// File: rtl/rl_channel.sv
module rl_channel #(
  parameter int ALLOW_W = rl_pkg::ALLOW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_i,
  input  logic               tick_i,
  input  logic               hit_i,
  input  logic [ALLOW_W-1:0] allow_i,
  output logic               vld_o,
  output logic               over_o
);
  localparam logic [ALLOW_W-1:0] CNT_MAX = '1;

  logic [ALLOW_W-1:0] cnt_q;
  logic [ALLOW_W-1:0] cnt_eff;
  logic [ALLOW_W-1:0] cnt_nxt;
  logic               vld_q;
  logic               over_q;
  logic               over_now;

  // a window start makes this cycle's packet the first of the new window
  assign cnt_eff  = (tick_i || !active_i) ? '0 : cnt_q;
  assign over_now = active_i && hit_i && (cnt_eff >= allow_i);

  always_comb begin
    cnt_nxt = cnt_eff;
    if (active_i && hit_i && (cnt_eff != CNT_MAX))
      cnt_nxt = cnt_eff + ALLOW_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      over_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      vld_q  <= hit_i;
      over_q <= over_now;
    end
  end

  assign vld_o  = vld_q;
  assign over_o = over_q;

  // R3
  vld_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(hit_i));
  // R3
  over_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_q |-> vld_q);
  // R5
  zero_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && hit_i && allow_i == '0) |=> over_q);
  // R4
  pass_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && hit_i && !tick_i && cnt_q < allow_i) |=> !over_q);
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !tick_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/pkt_rate_limiter.sv
module pkt_rate_limiter #(
  parameter int NUM_CH     = rl_pkg::NUM_CH,
  parameter int PRESCALE_W = rl_pkg::PRESCALE_W,
  parameter int ALLOW_W    = rl_pkg::ALLOW_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PRESCALE_W-1:0]       prescale,
  input  logic [NUM_CH*ALLOW_W-1:0]   allowance,
  input  logic [NUM_CH-1:0]           hit,
  output logic [NUM_CH-1:0]           verdict_vld,
  output logic [NUM_CH-1:0]           over_limit
);
  logic win_active;
  logic win_tick;

  rl_window_gen #(.PRESCALE_W(PRESCALE_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .prescale_i (prescale),
    .active_o   (win_active),
    .tick_o     (win_tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    rl_channel #(.ALLOW_W(ALLOW_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (win_active),
      .tick_i   (win_tick),
      .hit_i    (hit[g]),
      .allow_i  (allowance[g*ALLOW_W +: ALLOW_W]),
      .vld_o    (verdict_vld[g]),
      .over_o   (over_limit[g])
    );
  end

  // R6
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale == '0) |=> (over_limit == '0));
endmodule

// File: tb/pkt_rate_limiter_test.sv
module pkt_rate_limiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] P = 20'd20;
  logic [31:0] alw = 32'h0;
  logic [3:0]  hit = 4'h0;
  logic [3:0]  verdict_vld;
  logic [3:0]  over_limit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] q_exp[$];
  int         q_tag[$];
  int         mp = 0;
  int         mc[4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  pkt_rate_limiter uut (
    .clk(clk), .rst_n(rst_n), .prescale(P), .allowance(alw),
    .hit(hit), .verdict_vld(verdict_vld), .over_limit(over_limit)
  );

  task automatic report_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: applies one cycle of hits and queues the expected verdicts
  task automatic step(input logic [3:0] h, input int tag);
    logic       tk;
    logic [3:0] ev;
    logic [3:0] eo;
    int         eff;
    int         a;
    hit = h;
    tk = (P != 0) && (mp >= int'(P) - 1);
    for (int c = 0; c < 4; c++) begin
      a = int'(alw[c*8 +: 8]);
      eff = (P == 0) ? 0 : (tk ? 0 : mc[c]);
      ev[c] = h[c];
      eo[c] = h[c] && (P != 0) && (eff >= a);
      mc[c] = (P == 0) ? 0 : ((h[c] && eff < 255) ? eff + 1 : eff);
    end
    mp = (P == 0) ? 0 : (tk ? 0 : mp + 1);
    q_exp.push_back({ev, eo});
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares each cycle's verdicts against the queue
  logic [7:0] e_item;
  int         e_tag;
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      e_item = q_exp.pop_front();
      e_tag  = q_tag.pop_front();
      checks++;
      if ({verdict_vld, over_limit} !== e_item) begin
        errors++;
        $display("FAIL R%0d: vld=%b over=%b expected vld=%b over=%b at %0t",
                 e_tag, verdict_vld, over_limit, e_item[7:4], e_item[3:0], $time);
      end
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report_end();
    end
  end

  initial begin
    alw = {8'd1, 8'd5, 8'd0, 8'd3};
    hit = 4'h0;
    // R1: outputs stay low during reset even with hits applied
    repeat (3) begin
      @(negedge clk);
      hit = 4'hF;
      checks++;
      if (verdict_vld !== 4'h0 || over_limit !== 4'h0) begin
        errors++;
        $display("FAIL R1: vld=%b over=%b expected 0000/0000", verdict_vld, over_limit);
      end
    end
    hit = 4'h0;
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle after release carries no verdict
    step(4'h0, 1);
    // R4 R5 R8: per-channel allowances 3,0,5,1 under steady hits
    for (int i = 0; i < 8; i++) step(4'hF, 4);
    // R2 R9: hits continue across window starts
    for (int i = 0; i < 40; i++) step(4'hF, 2);
    for (int i = 0; i < 7; i++) step(4'h0, 2);
    for (int i = 0; i < 45; i++) step(4'h9, 9);
    // R8: random mix across channels
    for (int i = 0; i < 200; i++) step(4'($urandom % 16), 8);
    // R6: windows off, everything passes
    P = 20'd0;
    for (int i = 0; i < 30; i++) step(4'hF, 6);
    // R7: long window, allowance 255 on channel 2, 300 hits
    P = 20'd1000;
    alw[23:16] = 8'd255;
    for (int i = 0; i < 300; i++) step(4'h4, 7);
    // R6: re-disable then fresh window
    P = 20'd0;
    step(4'h0, 6);
    P = 20'd50;
    alw[23:16] = 8'd5;
    for (int i = 0; i < 30; i++) step(4'h1, 6);
    // R10: shrink window below current position
    P = 20'd10;
    for (int i = 0; i < 25; i++) step(4'h1, 10);
    // R2: one-cycle windows
    P = 20'd1;
    for (int i = 0; i < 10; i++) step(4'hF, 2);
    // R5: allowance zero on every channel
    P = 20'd30;
    alw = 32'h0;
    for (int i = 0; i < 12; i++) step(4'hF, 5);
    // R3: idle tail, no verdicts
    for (int i = 0; i < 5; i++) step(4'h0, 3);
    @(negedge clk);
    done = 1'b1;
    report_end();
  end
endmodule